// File: doc/BRIEF.md
# Cascaded Priority Keypad Encoder

This block turns ten active-low numeric key lines into the binary number of the pressed key. It also raises a flag whenever any key is down. Inside, the encoder is a chain of small four-input priority cells. Each cell reports its own local index and a group-select bit. Each cell also passes an enable down to the cells that cover lower-numbered keys. The highest cell holding an active key shuts off every cell below it. As a result, the highest-numbered pressed key always sets the code.

A synchronous stage follows the combinational encoder. This stage watches the any-key flag for a low-to-high change. On the clock edge where it sees that change, it stores the code and emits a single-cycle key-valid pulse. A control unit can therefore react once per key press rather than once per clock.

Top module: `key_priority_encoder`

## Requirements
- R1: Key lines are active low: a line at 0 is pressed. With exactly key k (0..9) pressed, `key_code` equals k in unsigned binary, so key 9 gives 4'b1001.
- R2: When several keys are pressed together, `key_code` gives the highest-numbered pressed key.
- R3: With every key line at 1, `key_code` is 4'b0000 and `any_key` is 0.
- R4: `any_key` is 1 exactly when at least one key line is 0.
- R5: `held_code` takes the value of `key_code` on the first rising clock edge at which `any_key` is 1 after an edge where it was 0. It then keeps that value while keys stay down and after they are released.
- R6: `key_strobe` is 1 for exactly one cycle after each capture edge. It does not repeat while `any_key` remains 1.
- R7: While `rst` is sampled high, `held_code` and `key_strobe` are cleared to 0.
- R8: Changing which keys are down while `any_key` stays 1 neither changes `held_code` nor raises `key_strobe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the capture stage |
| rst | input | 1 | Synchronous active-high reset |
| key_n | input | 10 | Numeric key lines, bit k is key k, active low |
| key_code | output | 4 | Combinational binary number of the winning key |
| any_key | output | 1 | Combinational group select, high when any key is pressed |
| held_code | output | 4 | Code registered at the start of a key press |
| key_strobe | output | 1 | One-cycle pulse marking a new key press |

## Verification
A broken enable link between cells lets a lower cell add its index bits to the output. This shows at once on `key_code` as a wrong number, but only for multi-key patterns that span two cells. The vector table therefore includes such patterns. A stale or wrongly reset edge-detect register shows within one clock edge: `key_strobe` repeats, goes missing, or `held_code` updates while a key is held. The directed sequences watch each of these cases one cycle after every change of the keys.

// File: rtl/kp_pkg.sv
package kp_pkg;
  // keys handled by one priority cell
  localparam int CELL_KEYS = 4;
  localparam int LOC_W     = $clog2(CELL_KEYS);

  function automatic int cells_for(input int n);
    return (n + CELL_KEYS - 1) / CELL_KEYS;
  endfunction

  function automatic int grp_bits(input int nc);
    return (nc > 1) ? $clog2(nc) : 1;
  endfunction
endpackage

// File: rtl/kp_enc_cell.sv
module kp_enc_cell #(
  parameter int W = 4
) (
  input  logic [W-1:0]         key_n,
  input  logic                 en_i,
  output logic [$clog2(W)-1:0] idx,
  output logic                 gs,
  output logic                 en_o
);
  localparam int LW = $clog2(W);

  logic          hit;
  logic [LW-1:0] raw;

  // later iterations override earlier ones: highest line wins
  always_comb begin
    hit = 1'b0;
    raw = '0;
    for (int i = 0; i < W; i++) begin
      if (!key_n[i]) begin
        hit = 1'b1;
        raw = LW'(i);
      end
    end
  end

  assign gs   = en_i & hit;
  assign idx  = en_i ? raw : '0;
  assign en_o = en_i & ~hit;
endmodule

// File: rtl/kp_group_merge.sv
module kp_group_merge #(
  parameter int NC = 3,
  parameter int LW = 2,
  parameter int GW = 2
) (
  input  logic [NC-1:0]    gs,
  input  logic [NC*LW-1:0] loc_flat,
  output logic [GW+LW-1:0] code,
  output logic             any
);
  logic [GW-1:0] grp;
  logic [LW-1:0] loc;

  // at most one cell is active, so OR-merging is exact
  always_comb begin
    grp = '0;
    loc = '0;
    for (int i = 0; i < NC; i++) begin
      if (gs[i]) grp = grp | GW'(i);
      loc = loc | loc_flat[i*LW +: LW];
    end
  end

  assign code = {grp, loc};
  assign any  = |gs;
endmodule

// File: rtl/kp_capture.sv
module kp_capture #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gs,
  input  logic [CW-1:0] code,
  output logic [CW-1:0] held,
  output logic          strobe
);
  logic gs_q;
  logic rise;

  assign rise = gs & ~gs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gs_q   <= 1'b0;
      held   <= '0;
      strobe <= 1'b0;
    end else begin
      gs_q   <= gs;
      strobe <= rise;
      if (rise) held <= code;
    end
  end
endmodule

// File: rtl/key_priority_encoder.sv
module key_priority_encoder
  import kp_pkg::*;
#(
  parameter int NUM_KEYS = 10,
  localparam int NC     = cells_for(NUM_KEYS),
  localparam int GW     = grp_bits(NC),
  localparam int CODE_W = GW + LOC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] key_n,
  output logic [CODE_W-1:0]   key_code,
  output logic                any_key,
  output logic [CODE_W-1:0]   held_code,
  output logic                key_strobe
);
  localparam int PAD = NC * CELL_KEYS;

  logic [PAD-1:0]      key_pad;
  logic [NC:0]         en;
  logic [NC-1:0]       gs;
  logic [NC*LOC_W-1:0] loc_flat;

  // unused upper lines read as released
  generate
    if (PAD > NUM_KEYS) begin : g_pad
      assign key_pad = {{(PAD - NUM_KEYS){1'b1}}, key_n};
    end else begin : g_nopad
      assign key_pad = key_n;
    end
  endgenerate

  // enable ripples from the top cell down
  assign en[NC] = 1'b1;

  generate
    for (genvar c = 0; c < NC; c++) begin : g_cell
      kp_enc_cell #(.W(CELL_KEYS)) u_cell (
        .key_n (key_pad[c*CELL_KEYS +: CELL_KEYS]),
        .en_i  (en[c+1]),
        .idx   (loc_flat[c*LOC_W +: LOC_W]),
        .gs    (gs[c]),
        .en_o  (en[c])
      );
    end
  endgenerate

  kp_group_merge #(.NC(NC), .LW(LOC_W), .GW(GW)) u_merge (
    .gs       (gs),
    .loc_flat (loc_flat),
    .code     (key_code),
    .any      (any_key)
  );

  kp_capture #(.CW(CODE_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .gs     (any_key),
    .code   (key_code),
    .held   (held_code),
    .strobe (key_strobe)
  );
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
  parameter int NUM_KEYS = 10,
  parameter int CODE_W   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_KEYS-1:0] key_n,
  input logic [CODE_W-1:0]   key_code,
  input logic                any_key,
  input logic [CODE_W-1:0]   held_code,
  input logic                key_strobe
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !any_key |-> key_code == '0); // R3
  AST_GS_MATCH: assert property (@(posedge clk) disable iff (rst) any_key == (key_n != '1)); // R4
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst) any_key |-> int'(key_code) < NUM_KEYS); // R1
  AST_CODE_IS_PRESSED: assert property (@(posedge clk) disable iff (rst) any_key |-> !key_n[key_code]); // R2
  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst) key_strobe |-> held_code == $past(key_code)); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) key_strobe |=> !key_strobe); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) !key_strobe |-> $stable(held_code)); // R8
endmodule

bind key_priority_encoder kp_checker #(.NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W)) u_kp_chk (
  .clk        (clk),
  .rst        (rst),
  .key_n      (key_n),
  .key_code   (key_code),
  .any_key    (any_key),
  .held_code  (held_code),
  .key_strobe (key_strobe)
);

// File: tb/test_key_priority_encoder.sv
module test_key_priority_encoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] key_n = '1;
  logic [3:0] key_code, held_code;
  logic       any_key, key_strobe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  key_priority_encoder i_key_priority_encoder (
    .clk(clk), .rst(rst), .key_n(key_n), .key_code(key_code),
    .any_key(any_key), .held_code(held_code), .key_strobe(key_strobe)
  );

  // {key_n[9:0], expected code, expected any_key}
  localparam logic [14:0] VEC [19] = '{
    {10'b1111111111, 4'd0, 1'b0},  // R3 idle
    {10'b1111111110, 4'd0, 1'b1},  // R1 single keys
    {10'b1111111101, 4'd1, 1'b1},
    {10'b1111111011, 4'd2, 1'b1},
    {10'b1111110111, 4'd3, 1'b1},
    {10'b1111101111, 4'd4, 1'b1},
    {10'b1111011111, 4'd5, 1'b1},
    {10'b1110111111, 4'd6, 1'b1},
    {10'b1101111111, 4'd7, 1'b1},
    {10'b1011111111, 4'd8, 1'b1},
    {10'b0111111111, 4'd9, 1'b1},
    {10'b0111111110, 4'd9, 1'b1},  // R2 multi-key
    {10'b1111100111, 4'd4, 1'b1},
    {10'b1111110001, 4'd3, 1'b1},
    {10'b1101011111, 4'd7, 1'b1},
    {10'b0000000000, 4'd9, 1'b1},
    {10'b1111111100, 4'd1, 1'b1},
    {10'b1000001111, 4'd8, 1'b1},
    {10'b1110101010, 4'd6, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: reset clears registers even with a key down
    key_n = 10'b1111011111;
    repeat (3) tick();
    check("R7 held_code", {4'd0, held_code}, 8'd0);
    check("R7 key_strobe", {7'd0, key_strobe}, 8'd0);
    key_n = '1;
    tick();
    rst = 1'b0;
    tick();

    // combinational table R1 R2 R3 R4
    for (int v = 0; v < 19; v++) begin
      key_n = VEC[v][14:5];
      #1;
      check("R1/R2 key_code", {4'd0, key_code}, {4'd0, VEC[v][4:1]});
      check("R3/R4 any_key", {7'd0, any_key}, {7'd0, VEC[v][0]});
      tick();
    end
    key_n = '1;
    tick();
    tick();
    check("R6 idle strobe", {7'd0, key_strobe}, 8'd0);

    // R5 R6 capture of key 6
    key_n = 10'b1110111111;
    tick();
    check("R6 strobe on press", {7'd0, key_strobe}, 8'd1);
    check("R5 captured", {4'd0, held_code}, 8'd6);
    tick();
    check("R6 single pulse", {7'd0, key_strobe}, 8'd0);

    // R8 roll to key 9 while held
    key_n = 10'b0110111111;
    tick();
    check("R8 no strobe on roll", {7'd0, key_strobe}, 8'd0);
    check("R8 held kept", {4'd0, held_code}, 8'd6);
    key_n = 10'b0111111111;
    tick();
    check("R8 held kept after change", {4'd0, held_code}, 8'd6);

    // R5 release keeps value
    key_n = '1;
    tick();
    tick();
    check("R5 held after release", {4'd0, held_code}, 8'd6);
    check("R6 no strobe on release", {7'd0, key_strobe}, 8'd0);

    // R2 R5 two-key press captures higher
    key_n = 10'b1011111011;
    tick();
    check("R2 capture priority", {4'd0, held_code}, 8'd8);
    check("R6 strobe second press", {7'd0, key_strobe}, 8'd1);
    tick();
    check("R6 pulse ends", {7'd0, key_strobe}, 8'd0);

    // R5 new press of key 3
    key_n = '1;
    tick();
    key_n = 10'b1111110111;
    tick();
    check("R5 recapture", {4'd0, held_code}, 8'd3);
    check("R6 strobe third press", {7'd0, key_strobe}, 8'd1);

    // R7 reset mid-press
    rst = 1'b1;
    tick();
    check("R7 held cleared", {4'd0, held_code}, 8'd0);
    check("R7 strobe cleared", {7'd0, key_strobe}, 8'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule